// File: doc/BRIEF.md
# Ethernet Port Power-State Manager

This block sits beside an Ethernet MAC/PHY pair and decides how much of the port stays powered and which speeds it advertises. It watches the device power state (working or D3), the system power source (mains or battery), and the link status. From these it issues autonegotiation restarts with a chosen advertisement mask. It lowers the advertised speed when the device goes into D3 with a gigabit link, or when the system moves to battery. When the cable carries no receive energy and no link is up, the block puts the PHY into power-down. It can also ask for the supply rails to be removed.

While powered down, the block wakes the PHY at a programmable interval for a short listen window and strobes an autonegotiation restart. Two partners that use the same scheme therefore cannot both sit asleep forever. Any receive energy, whether seen asleep or during a listen window, brings the port up at once. In D3 the block drives an active-low wake output when an external filter reports a matching wake packet, or when the link comes up with link-change wake enabled. The wake output holds until the device returns to the working state.

All inputs and outputs are plain control and status pins. The block moves no data stream, so it has no valid/ready interface.

Top module: `lan_pm_ctrl`

## Requirements
- R1: While rst_n is low: phy_pd_req=0, deep_pd_req=0, an_restart=0, an_adv_mask=3'b111 and pme_n=1.
- R2: The mask bits mean: bit0 = 10 Mb/s, bit1 = 100 Mb/s, bit2 = 1000 Mb/s. The mask is chosen from the inputs seen at the edge that raises an_restart. On battery it is the lowest set bit of partner_abil, or 3'b001 when partner_abil is zero. Otherwise, in D3 it is 3'b011. Otherwise it is 3'b111. an_adv_mask is loaded only together with an_restart and holds between strobes.
- R3: A rise of dev_d3 seen at an edge while link_up=1 and link_speed=2'b10 (gigabit; 2'b00 is 10, 2'b01 is 100) gives a one-cycle an_restart after that edge. With any other speed, or with the link down, the rise gives no restart.
- R4: Any change of on_battery seen while link_up=1 gives a one-cycle an_restart after that edge. A change with the link down gives no restart.
- R5: With pd_en=1, link_up=0 and rx_energy=0 in the active state, phy_pd_req rises after the next edge. deep_pd_req equals phy_pd_req AND deep_pd_en.
- R6: After retry_interval cycles asleep (0 counts as 1), phy_pd_req and deep_pd_req drop for LISTEN_CYC cycles, with an_restart high in the first of them. If no energy is seen in that window, the port returns to sleep.
- R7: rx_energy=1 seen while asleep or listening drops phy_pd_req after that edge and strobes an_restart with the mask of R2.
- R8: In D3, wake_pkt_match=1 drives pme_n low after the next edge. In D0 the match is ignored.
- R9: In D3 with link_wake_en=1, a rise of link_up drives pme_n low after that edge. With link_wake_en=0 the rise has no effect.
- R10: pme_n stays low while dev_d3=1 and returns high after the first edge at which dev_d3=0.
- R11: pd_en=0 seen while asleep returns the port to the active state after that edge, without an_restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_d3 | input | 1 | Device in D3 (1) or D0 (0) |
| on_battery | input | 1 | System runs on battery |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | Current link speed code |
| partner_abil | input | ADV_W | Speeds the link partner advertises, mask encoding of R2 |
| rx_energy | input | 1 | Receive energy detected on the line |
| pd_en | input | 1 | Allow energy-detect power-down |
| deep_pd_en | input | 1 | Also request rail removal when asleep |
| retry_interval | input | CNT_W | Sleep cycles between link-setup retries |
| wake_pkt_match | input | 1 | External filter matched a wake packet |
| link_wake_en | input | 1 | Wake on link coming up |
| phy_pd_req | output | 1 | PHY power-down request |
| deep_pd_req | output | 1 | Supply rail removal request |
| an_restart | output | 1 | One-cycle autonegotiation restart strobe |
| an_adv_mask | output | ADV_W | Speeds to advertise |
| pme_n | output | 1 | Active-low wake output |

## Verification
Every result is registered once. Each output changes right after the first rising edge that samples its cause, and never later. The bench changes inputs 1 ns after an edge and reads outputs 1 ns after the following edge. It checks a strobe in exactly that window and checks that it is gone one cycle later. For the retry sweep, sleep and listen lengths are counted edge by edge against retry_interval and LISTEN_CYC.

// File: rtl/lan_pm_pkg.sv
package lan_pm_pkg;
  typedef enum logic [1:0] {
    PD_ACTIVE = 2'd0,
    PD_SLEEP  = 2'd1,
    PD_LISTEN = 2'd2
  } pd_state_e;

  localparam logic [1:0] SPEED_GIG = 2'b10;
endpackage

// File: rtl/lan_pm_adv_sel.sv
module lan_pm_adv_sel #(
  parameter int ADV_W = 3,
  parameter logic [ADV_W-1:0] D3_ADV = 3'b011
) (
  input  logic             d3,
  input  logic             battery,
  input  logic [ADV_W-1:0] partner,
  output logic [ADV_W-1:0] mask
);
  logic [ADV_W-1:0] lowest;

  // lowest common speed: scan from the top so the last hit is the lowest bit
  always_comb begin
    lowest = {{(ADV_W-1){1'b0}}, 1'b1};
    for (int i = ADV_W-1; i >= 0; i--) begin
      if (partner[i]) lowest = ADV_W'(1) << i;
    end
  end

  always_comb begin
    if (battery)  mask = lowest;
    else if (d3)  mask = D3_ADV;
    else          mask = '1;
  end
endmodule

// File: rtl/lan_pm_energy_fsm.sv
module lan_pm_energy_fsm
  import lan_pm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LISTEN_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_en,
  input  logic             deep_en,
  input  logic             link_up,
  input  logic             rx_energy,
  input  logic [CNT_W-1:0] retry_interval,
  output logic             restart_req,
  output logic             pd_req,
  output logic             deep_req
);
  localparam logic [CNT_W-1:0] LISTEN_LAST = CNT_W'(LISTEN_CYC - 1);

  pd_state_e        st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W:0]   cnt_inc;
  logic             retry_hit;

  assign cnt_inc   = {1'b0, cnt} + (CNT_W+1)'(1);
  assign retry_hit = cnt_inc >= {1'b0, retry_interval};

  always_comb begin
    st_n        = st;
    cnt_n       = cnt;
    restart_req = 1'b0;
    unique case (st)
      PD_ACTIVE: begin
        if (pd_en && !link_up && !rx_energy) begin
          st_n  = PD_SLEEP;
          cnt_n = '0;
        end
      end
      PD_SLEEP: begin
        if (rx_energy) begin
          st_n        = PD_ACTIVE;
          restart_req = 1'b1;
        end else if (!pd_en) begin
          st_n = PD_ACTIVE;
        end else if (retry_hit) begin
          st_n        = PD_LISTEN;
          cnt_n       = '0;
          restart_req = 1'b1;
        end else begin
          cnt_n = cnt_inc[CNT_W-1:0];
        end
      end
      PD_LISTEN: begin
        if (rx_energy) begin
          st_n        = PD_ACTIVE;
          restart_req = 1'b1;
        end else if (!pd_en) begin
          st_n = PD_ACTIVE;
        end else if (cnt == LISTEN_LAST) begin
          st_n  = PD_SLEEP;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_inc[CNT_W-1:0];
        end
      end
      default: st_n = PD_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PD_ACTIVE;
      cnt      <= '0;
      deep_req <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      deep_req <= (st_n == PD_SLEEP) && deep_en;
    end
  end

  assign pd_req = (st == PD_SLEEP);
endmodule

// File: rtl/lan_pm_wake.sv
module lan_pm_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic d3,
  input  logic pkt_match,
  input  logic link_wake_en,
  input  logic link_rise,
  output logic pme_n
);
  logic pme_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   pme_q <= 1'b0;
    else if (!d3)                                 pme_q <= 1'b0;
    else if (pkt_match || (link_wake_en && link_rise)) pme_q <= 1'b1;
  end

  assign pme_n = ~pme_q;
endmodule

// File: rtl/lan_pm_ctrl.sv
module lan_pm_ctrl
  import lan_pm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LISTEN_CYC = 8,
  parameter int ADV_W      = 3,
  parameter logic [ADV_W-1:0] D3_ADV = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_d3,
  input  logic             on_battery,
  input  logic             link_up,
  input  logic [1:0]       link_speed,
  input  logic [ADV_W-1:0] partner_abil,
  input  logic             rx_energy,
  input  logic             pd_en,
  input  logic             deep_pd_en,
  input  logic [CNT_W-1:0] retry_interval,
  input  logic             wake_pkt_match,
  input  logic             link_wake_en,
  output logic             phy_pd_req,
  output logic             deep_pd_req,
  output logic             an_restart,
  output logic [ADV_W-1:0] an_adv_mask,
  output logic             pme_n
);
  logic             d3_q, batt_q, link_q;
  logic             d3_rise, batt_chg, link_rise;
  logic             speed_evt, fsm_restart, restart_d;
  logic [ADV_W-1:0] sel_mask;

  assign d3_rise   = dev_d3 & ~d3_q;
  assign batt_chg  = on_battery ^ batt_q;
  assign link_rise = link_up & ~link_q;

  assign speed_evt = link_up & ((d3_rise & (link_speed == SPEED_GIG)) | batt_chg);
  assign restart_d = speed_evt | fsm_restart;

  lan_pm_adv_sel #(.ADV_W(ADV_W), .D3_ADV(D3_ADV)) u_sel (
    .d3      (dev_d3),
    .battery (on_battery),
    .partner (partner_abil),
    .mask    (sel_mask)
  );

  lan_pm_energy_fsm #(.CNT_W(CNT_W), .LISTEN_CYC(LISTEN_CYC)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .pd_en          (pd_en),
    .deep_en        (deep_pd_en),
    .link_up        (link_up),
    .rx_energy      (rx_energy),
    .retry_interval (retry_interval),
    .restart_req    (fsm_restart),
    .pd_req         (phy_pd_req),
    .deep_req       (deep_pd_req)
  );

  lan_pm_wake u_wake (
    .clk          (clk),
    .rst_n        (rst_n),
    .d3           (dev_d3),
    .pkt_match    (wake_pkt_match),
    .link_wake_en (link_wake_en),
    .link_rise    (link_rise),
    .pme_n        (pme_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d3_q        <= 1'b0;
      batt_q      <= 1'b0;
      link_q      <= 1'b0;
      an_restart  <= 1'b0;
      an_adv_mask <= '1;
    end else begin
      d3_q       <= dev_d3;
      batt_q     <= on_battery;
      link_q     <= link_up;
      an_restart <= restart_d;
      if (restart_d) an_adv_mask <= sel_mask;
    end
  end
endmodule

// File: rtl/lan_pm_ctrl_chk.sv
module lan_pm_ctrl_chk #(
  parameter int ADV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dev_d3,
  input logic             on_battery,
  input logic             rx_energy,
  input logic             phy_pd_req,
  input logic             deep_pd_req,
  input logic             an_restart,
  input logic [ADV_W-1:0] an_adv_mask,
  input logic             pme_n
);
  // R5: rail removal only ever accompanies PHY power-down
  a_r5_deep_implies_pd: assert property (@(posedge clk) disable iff (!rst_n)
    deep_pd_req |-> phy_pd_req);

  // R7: energy while asleep wakes the port and restarts autonegotiation
  a_r7_energy_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_pd_req && rx_energy) |=> (!phy_pd_req && an_restart));

  // R2: on battery exactly one speed is advertised
  a_r2_battery_single_speed: assert property (@(posedge clk) disable iff (!rst_n)
    (an_restart && $past(on_battery)) |-> ($countones(an_adv_mask) == 1));

  // R10: wake output released once the device is back in D0
  a_r10_pme_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_d3 |=> pme_n);

  // R8: wake output only falls when D3 was seen
  a_r8_pme_only_d3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pme_n) |-> $past(dev_d3));
endmodule

bind lan_pm_ctrl lan_pm_ctrl_chk #(.ADV_W(ADV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dev_d3      (dev_d3),
  .on_battery  (on_battery),
  .rx_energy   (rx_energy),
  .phy_pd_req  (phy_pd_req),
  .deep_pd_req (deep_pd_req),
  .an_restart  (an_restart),
  .an_adv_mask (an_adv_mask),
  .pme_n       (pme_n)
);

// File: tb/lan_pm_ctrl_bench.sv
module lan_pm_ctrl_bench;
  localparam int CW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dev_d3 = 0, on_battery = 0, link_up = 0, rx_energy = 0;
  logic [1:0]    link_speed = 2'b00;
  logic [2:0]    partner_abil = 3'b111;
  logic          pd_en = 0, deep_pd_en = 0, wake_pkt_match = 0, link_wake_en = 0;
  logic [CW-1:0] retry_interval = '0;
  logic          phy_pd_req, deep_pd_req, an_restart, pme_n;
  logic [2:0]    an_adv_mask;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lan_pm_ctrl #(.CNT_W(CW), .LISTEN_CYC(LW), .ADV_W(3), .D3_ADV(3'b011)) u_lan_pm_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_d3(dev_d3), .on_battery(on_battery),
    .link_up(link_up), .link_speed(link_speed), .partner_abil(partner_abil),
    .rx_energy(rx_energy), .pd_en(pd_en), .deep_pd_en(deep_pd_en),
    .retry_interval(retry_interval), .wake_pkt_match(wake_pkt_match),
    .link_wake_en(link_wake_en), .phy_pd_req(phy_pd_req), .deep_pd_req(deep_pd_req),
    .an_restart(an_restart), .an_adv_mask(an_adv_mask), .pme_n(pme_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    chk("R1 pd", phy_pd_req, 0);
    chk("R1 deep", deep_pd_req, 0);
    chk("R1 restart", an_restart, 0);
    chk("R1 mask", an_adv_mask, 7);
    chk("R1 pme", pme_n, 1);
    rst_n = 1;
    repeat (2) tick();

    // R3: D3 entry with link up, sweep over speed codes
    link_up = 1;
    for (int s = 0; s < 4; s++) begin
      link_speed = 2'(s);
      dev_d3 = 0; repeat (2) tick();
      dev_d3 = 1; tick();
      chk("R3 d3 entry strobe", an_restart, (s == 2) ? 1 : 0);
      if (s == 2) chk("R2 d3 mask", an_adv_mask, 3);
      tick();
      chk("R3 strobe one cycle", an_restart, 0);
    end
    dev_d3 = 0; link_up = 0; tick();
    dev_d3 = 1; link_speed = 2'b10; tick();
    chk("R3 no strobe link down", an_restart, 0);
    dev_d3 = 0; tick();

    // R4/R2: battery changes, sweep over partner abilities
    link_up = 1; link_speed = 2'b10; tick();
    for (int p = 0; p < 8; p++) begin
      int exp_mask;
      exp_mask = (p == 0) ? 1 : (p & -p);
      partner_abil = 3'(p);
      on_battery = 1; tick();
      chk("R4 battery on strobe", an_restart, 1);
      chk("R2 battery mask", an_adv_mask, exp_mask);
      tick();
      chk("R2 mask held", an_adv_mask, exp_mask);
      on_battery = 0; tick();
      chk("R4 battery off strobe", an_restart, 1);
      chk("R2 mains mask", an_adv_mask, 7);
      tick();
    end
    link_up = 0; tick();
    on_battery = 1; tick();
    chk("R4 no strobe link down", an_restart, 0);
    on_battery = 0; tick();
    chk("R4 no strobe link down off", an_restart, 0);

    // R5/R6: sleep and listen timing, sweep retry interval
    for (int r = 0; r < 6; r++) begin
      int rr;
      rr = (r == 0) ? 1 : r;
      retry_interval = CW'(r);
      deep_pd_en = r[0];
      pd_en = 1; tick();
      chk("R5 pd entry", phy_pd_req, 1);
      chk("R5 deep follows enable", deep_pd_req, r & 1);
      for (int k = 1; k < rr; k++) begin
        tick();
        chk("R6 still asleep", phy_pd_req, 1);
        chk("R6 no early strobe", an_restart, 0);
      end
      tick();
      chk("R6 listen pd off", phy_pd_req, 0);
      chk("R6 listen deep off", deep_pd_req, 0);
      chk("R6 retry strobe", an_restart, 1);
      for (int k = 1; k < LW; k++) begin
        tick();
        chk("R6 listening", phy_pd_req, 0);
        chk("R6 single retry strobe", an_restart, 0);
      end
      tick();
      chk("R6 back to sleep", phy_pd_req, 1);
      rx_energy = 1; pd_en = 0; tick();
      chk("R7 energy exit", phy_pd_req, 0);
      chk("R7 energy strobe", an_restart, 1);
      chk("R7 mask mains", an_adv_mask, 7);
      rx_energy = 0; tick();
    end

    // R7: energy during listen window, in D3 on mains
    dev_d3 = 1; retry_interval = 2; pd_en = 1; tick();
    tick(); tick();
    chk("R6 in listen", phy_pd_req, 0);
    rx_energy = 1; tick();
    chk("R7 listen energy strobe", an_restart, 1);
    chk("R7 d3 mask", an_adv_mask, 3);
    rx_energy = 0; pd_en = 0; tick();
    tick();
    chk("R7 stays active", phy_pd_req, 0);

    // R11: pd_en dropped while asleep
    retry_interval = 100; pd_en = 1; tick();
    chk("R11 asleep", phy_pd_req, 1);
    pd_en = 0; tick();
    chk("R11 wake pd", phy_pd_req, 0);
    chk("R11 no strobe", an_restart, 0);
    dev_d3 = 0; tick();

    // R8/R10: wake packet
    wake_pkt_match = 1; tick();
    chk("R8 ignored in D0", pme_n, 1);
    wake_pkt_match = 0; dev_d3 = 1; tick();
    wake_pkt_match = 1; tick();
    chk("R8 match in D3", pme_n, 0);
    wake_pkt_match = 0;
    repeat (3) tick();
    chk("R10 held", pme_n, 0);
    dev_d3 = 0; tick();
    chk("R10 cleared", pme_n, 1);

    // R9: link change wake
    dev_d3 = 1; link_wake_en = 0; tick();
    link_up = 1; tick();
    chk("R9 disabled no wake", pme_n, 1);
    link_up = 0; link_wake_en = 1; tick();
    chk("R9 link fall no wake", pme_n, 1);
    link_up = 1; tick();
    chk("R9 link rise wake", pme_n, 0);
    dev_d3 = 0; tick();
    chk("R10 cleared link", pme_n, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule